// File: doc/BRIEF.md
# Interrupt Aggregation Controller

This block gathers the interrupt events of a device endpoint and folds them onto a small set of interrupt outputs. It takes events from internal logic and from general-purpose input pins. Each event sets a sticky pending bit in one shared status word. Software can read that word at any time, whatever the output settings, so a driver may poll it instead of taking interrupts. Each output has its own configuration word. The word holds a source mask and a delivery-mode bit. In level mode the output drives a legacy wire while any unmasked source is pending. In message mode it raises a request toward a message generator and holds it until that generator accepts it.

Software uses a small register port. Address 0 is the status word and address 1+o is the configuration word of output o. Reads are combinational and never change state. A pending bit is cleared only by writing a 1 to its position in the status word. The message requests use a valid/ready pair per output. `msi_req_o[o]` is the valid and `msi_ack_i[o]` is the ready. A raised request stays high until a cycle in which both are high; this is the back-pressure rule. Acceptance happens on the clock edge where both are high. An ack while the request is low is ignored.

Top module: `irq_aggregator`

## Requirements
- R1: A source input that is high at a rising clock edge sets its status bit at that edge. The bit stays set until it is cleared. Internal sources occupy status bits 15:0 and pin sources occupy bits 23:16.
- R2: The status word is read at address 0, with bits 23:0 pending and bits 31:24 zero. It is readable and correct even when every output mask is zero.
- R3: A write to address 0 clears exactly the status bits whose write-data bits are 1. All other pending bits keep their value.
- R4: If a source event and a clear of the same bit fall on the same edge, the bit ends up set.
- R5: Reading any address has no side effect. Repeated reads return the same value and leave the outputs unchanged.
- R6: Output o has its configuration at address 1+o. Bit 31 is the mode (0 = level, 1 = message) and bits 23:0 are the source mask. Bits 30:24 read as zero.
- R7: In level mode, `intx_o[o]` is high exactly when status AND mask of output o is nonzero. It follows the status register with no extra delay.
- R8: In message mode, `msi_req_o[o]` rises one edge after the masked status of o turns from zero to nonzero. It then holds until accepted.
- R9: After an accepted request, if masked status is still nonzero on the next edge, the request rises again at that edge. Otherwise it stays low.
- R10: An output in message mode keeps `intx_o` low. An output in level mode keeps `msi_req_o` low.
- R11: After reset, status and every configuration word are zero and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_irq_i | input | 16 | Internal interrupt events (status bits 15:0) |
| gpio_irq_i | input | 8 | Pin interrupt events (status bits 23:16) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from address) |
| intx_o | output | 8 | Level interrupt per output |
| msi_req_o | output | 8 | Message request valid per output |
| msi_ack_i | input | 8 | Message request ready/accept per output |

## Verification
The status bits, the read data and the level outputs change at the edge that samples the source or the write. The bench therefore checks them 1 ns after that same edge. A message request appears one edge later than the status bit. A re-request appears one edge after the accepting edge. The bench steps one edge at a time and samples exactly at those points. Inputs are driven 1 ns after an edge and results are read before the next edge, so no check sits on a clock edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic {
    MODE_LEVEL = 1'b0,
    MODE_MSG   = 1'b1
  } irq_mode_e;

  localparam int STATUS_ADDR = 0;
  localparam int CFG_BASE    = 1;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int NSRC = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] status_o
);
  logic [NSRC-1:0] pend_q;

  // set beats clear: the OR is applied after the mask
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign status_o = pend_q;
endmodule

// File: rtl/irq_out_lane.sv
module irq_out_lane
  import irq_agg_pkg::*;
#(
  parameter int NSRC = 24,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we_i,
  input  logic            cfg_mode_i,
  input  logic [NSRC-1:0] cfg_mask_i,
  input  logic [NSRC-1:0] status_i,
  input  logic            ack_i,
  output logic [DW-1:0]   cfg_o,
  output logic            intx_o,
  output logic            req_o
);
  localparam int MODE_BIT = DW - 1;

  irq_mode_e       mode_q;
  logic [NSRC-1:0] mask_q;
  logic            pend;
  logic            prev_q;
  logic            req_q;
  logic            recheck_q;

  assign pend = |(status_i & mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= MODE_LEVEL;
      mask_q    <= '0;
      prev_q    <= 1'b0;
      req_q     <= 1'b0;
      recheck_q <= 1'b0;
    end else begin
      if (cfg_we_i) begin
        mode_q <= irq_mode_e'(cfg_mode_i);
        mask_q <= cfg_mask_i;
      end
      prev_q <= pend;
      if (mode_q != MODE_MSG) begin
        req_q     <= 1'b0;
        recheck_q <= 1'b0;
      end else if (req_q) begin
        if (ack_i) begin
          req_q     <= 1'b0;
          recheck_q <= 1'b1;
        end
      end else begin
        req_q     <= pend && (!prev_q || recheck_q);
        recheck_q <= 1'b0;
      end
    end
  end

  always_comb begin
    cfg_o                = '0;
    cfg_o[MODE_BIT]      = (mode_q == MODE_MSG);
    cfg_o[NSRC-1:0]      = mask_q;
  end

  assign intx_o = pend && (mode_q == MODE_LEVEL);
  assign req_o  = req_q;
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_agg_pkg::*;
#(
  parameter int NSRC  = 24,
  parameter int N_OUT = 8,
  parameter int AW    = 4,
  parameter int DW    = 32
) (
  input  logic [AW-1:0]       addr_i,
  input  logic [NSRC-1:0]     status_i,
  input  logic [N_OUT*DW-1:0] cfg_flat_i,
  output logic [DW-1:0]       rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(STATUS_ADDR)) rdata_o[NSRC-1:0] = status_i;
    for (int o = 0; o < N_OUT; o++) begin
      if (addr_i == AW'(CFG_BASE + o)) rdata_o = cfg_flat_i[o*DW +: DW];
    end
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int N_CORE = 16,
  parameter int N_GPIO = 8,
  parameter int N_OUT  = 8,
  parameter int AW     = 4,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CORE-1:0] core_irq_i,
  input  logic [N_GPIO-1:0] gpio_irq_i,
  input  logic              reg_wr_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic [N_OUT-1:0]  intx_o,
  output logic [N_OUT-1:0]  msi_req_o,
  input  logic [N_OUT-1:0]  msi_ack_i
);
  localparam int NSRC = N_CORE + N_GPIO;

  logic [NSRC-1:0]     src_all;
  logic [NSRC-1:0]     clr_bits;
  logic [NSRC-1:0]     stat_w;
  logic [N_OUT*DW-1:0] cfg_flat;
  logic                unused_wdata;

  assign src_all      = {gpio_irq_i, core_irq_i};
  assign clr_bits     = (reg_wr_i && reg_addr_i == AW'(STATUS_ADDR)) ?
                        reg_wdata_i[NSRC-1:0] : '0;
  assign unused_wdata = ^reg_wdata_i[DW-2:NSRC];

  irq_status_bank #(.NSRC(NSRC)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (src_all),
    .clr_i    (clr_bits),
    .status_o (stat_w)
  );

  for (genvar o = 0; o < N_OUT; o++) begin : g_lane
    irq_out_lane #(.NSRC(NSRC), .DW(DW)) u_lane (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we_i   (reg_wr_i && reg_addr_i == AW'(CFG_BASE + o)),
      .cfg_mode_i (reg_wdata_i[DW-1]),
      .cfg_mask_i (reg_wdata_i[NSRC-1:0]),
      .status_i   (stat_w),
      .ack_i      (msi_ack_i[o]),
      .cfg_o      (cfg_flat[o*DW +: DW]),
      .intx_o     (intx_o[o]),
      .req_o      (msi_req_o[o])
    );
  end

  irq_read_mux #(.NSRC(NSRC), .N_OUT(N_OUT), .AW(AW), .DW(DW)) u_rmux (
    .addr_i     (reg_addr_i),
    .status_i   (stat_w),
    .cfg_flat_i (cfg_flat),
    .rdata_o    (reg_rdata_o)
  );
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int NSRC  = 24,
  parameter int N_OUT = 8,
  parameter int AW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSRC-1:0]  srcs,
  input logic [NSRC-1:0]  status,
  input logic             reg_wr,
  input logic [AW-1:0]    reg_addr,
  input logic [NSRC-1:0]  clr_data,
  input logic [N_OUT-1:0] intx,
  input logic [N_OUT-1:0] req,
  input logic [N_OUT-1:0] ack
);
  logic [NSRC-1:0] clr_req;
  assign clr_req = (reg_wr && reg_addr == '0) ? clr_data : '0;

  // R1 and R4: an event always leaves its bit set, even under a clear
  a_r1_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (srcs != '0) |=> ((status & $past(srcs)) == $past(srcs)));

  // R3: bits not named by a clear stay pending
  a_r3_clear_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ($past(status) & ~$past(clr_req))) ==
              ($past(status) & ~$past(clr_req))));

  // R3: with no event and no clear, status is frozen
  a_r3_status_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (srcs == '0 && clr_req == '0) |=> $stable(status));

  // R10: an output never signals both ways at once
  a_r10_mode_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (intx & req) == '0);

  // R8: a request waits for ready while configuration is untouched
  a_r8_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((req & ~ack) != '0 && !reg_wr) |=> (($past(req & ~ack) & ~req) == '0));
endmodule

bind irq_aggregator irq_aggregator_chk #(
  .NSRC(NSRC), .N_OUT(N_OUT), .AW(AW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .srcs     (src_all),
  .status   (stat_w),
  .reg_wr   (reg_wr_i),
  .reg_addr (reg_addr_i),
  .clr_data (reg_wdata_i[NSRC-1:0]),
  .intx     (intx_o),
  .req      (msi_req_o),
  .ack      (msi_ack_i)
);

// File: tb/irq_aggregator_test.sv
`timescale 1ns/1ps
module irq_aggregator_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] core_irq = '0;
  logic [7:0]  gpio_irq = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  intx;
  logic [7:0]  msi_req;
  logic [7:0]  msi_ack = '0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_aggregator uut (
    .clk(clk), .rst_n(rst_n), .core_irq_i(core_irq), .gpio_irq_i(gpio_irq),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .intx_o(intx), .msi_req_o(msi_req),
    .msi_ack_i(msi_ack)
  );

  // {source bits, clear bits, expected status}
  localparam logic [71:0] VEC [10] = '{
    {24'h000001, 24'h000000, 24'h000001},
    {24'h010000, 24'h000000, 24'h010001},
    {24'h000000, 24'h000000, 24'h010001},
    {24'h000000, 24'h000001, 24'h010000},
    {24'h000002, 24'h000002, 24'h010002},
    {24'h800000, 24'h010000, 24'h800002},
    {24'h000000, 24'hFFFFFF, 24'h000000},
    {24'hABCDEF, 24'h000000, 24'hABCDEF},
    {24'h000000, 24'h00000F, 24'hABCDE0},
    {24'h000000, 24'hFFFFFF, 24'h000000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();

    // R11 reset state
    rd(4'd0, d); chk("R11 status", d, 32'h0);
    rd(4'd3, d); chk("R11 cfg", d, 32'h0);
    chk("R11 intx", {24'h0, intx}, 32'h0);
    chk("R11 req", {24'h0, msi_req}, 32'h0);

    // R1 R2 R3 R4 table walk, all masks zero
    foreach (VEC[i]) begin
      {gpio_irq, core_irq} = VEC[i][71:48];
      if (VEC[i][47:24] != '0) begin
        reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = {8'h0, VEC[i][47:24]};
      end
      cyc();
      reg_wr = 1'b0; reg_wdata = '0; core_irq = '0; gpio_irq = '0;
      rd(4'd0, d);
      chk($sformatf("R1/R2/R3/R4 vec%0d", i), d, {8'h0, VEC[i][23:0]});
      chk("R2 no intx with zero masks", {24'h0, intx}, 32'h0);
    end

    // R6 configuration field layout
    wr(4'd2, 32'hFFFF_FFFF);
    rd(4'd2, d); chk("R6 cfg1 readback", d, 32'h80FF_FFFF);
    rd(4'd1, d); chk("R6 cfg0 untouched", d, 32'h0);
    wr(4'd2, 32'h0);

    // R5 reads have no side effect
    core_irq = 16'h0100; cyc(); core_irq = '0;
    rd(4'd0, d); cyc(); rd(4'd0, d2);
    chk("R5 repeated read", d2, d);
    chk("R5 value", d2, 32'h0000_0100);
    wr(4'd0, 32'h0000_0100);

    // R7 level mode on output 0, mask bit 2
    wr(4'd1, 32'h0000_0004);
    core_irq = 16'h0008; cyc(); core_irq = '0;
    chk("R7 unmasked source ignored", {31'h0, intx[0]}, 32'h0);
    core_irq = 16'h0004; cyc(); core_irq = '0;
    chk("R7 intx0 asserted", {24'h0, intx}, 32'h01);
    chk("R10 no req in level mode", {24'h0, msi_req}, 32'h0);
    wr(4'd0, 32'h0000_0004);
    chk("R7 intx0 drops after clear", {24'h0, intx}, 32'h0);
    wr(4'd0, 32'h0000_0008);
    wr(4'd1, 32'h0);

    // R8 R9 message mode on output 2, mask bit 4
    wr(4'd3, 32'h8000_0010);
    core_irq = 16'h0010; cyc(); core_irq = '0;
    chk("R8 no req on status edge", {31'h0, msi_req[2]}, 32'h0);
    cyc();
    chk("R8 req raised", {24'h0, msi_req}, 32'h04);
    chk("R10 no intx in message mode", {24'h0, intx}, 32'h0);
    cyc();
    chk("R8 req held without ready", {31'h0, msi_req[2]}, 32'h1);
    msi_ack[2] = 1'b1; cyc(); msi_ack[2] = 1'b0;
    chk("R9 req drops on accept", {31'h0, msi_req[2]}, 32'h0);
    cyc();
    chk("R9 re-request while pending", {31'h0, msi_req[2]}, 32'h1);
    msi_ack[2] = 1'b1; reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h10;
    cyc();
    msi_ack[2] = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    chk("R9 accepted with clear", {31'h0, msi_req[2]}, 32'h0);
    cyc();
    chk("R9 no re-request when idle", {31'h0, msi_req[2]}, 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule